// File: doc/BRIEF.md
# Multi-Master I2C Arbitrating Transmitter

This block is the bit and byte engine of an I2C master that shares its bus with other masters. It pulls SDA low through an open-drain enable and never drives it high. It follows the bus through two synchronised copies of SCL and SDA. Software, or a sequencer above it, writes commands with an optional data byte. The commands are: take the bus with a START, send a byte, and let the bus go with a STOP. A START issued while the block already holds the bus becomes a repeated START, and no STOP comes before it.

SCL is not made here. A separate clock-synchronisation block runs the wired-AND clock whenever `run_o` is high. It reports the bit phases with two one-cycle strobes: one at the middle of each SCL low phase, and one at the middle of each SCL high phase. The engine changes SDA only on the low-phase strobe, apart from the START and STOP edges. It reads the bus on the high-phase strobe. That read drives the acknowledge bit and the bit-by-bit arbitration check. When another master wins a bit, the engine lets go of SDA at once and leaves the bus without a STOP. It then falls back to slave-receive mode and raises a sticky flag.

Top module: `i2c_arb_master`

## Requirements
- R1: When the bus is free, command code 1 (START) releases SDA and asks for clock. At the first high-phase strobe it pulls SDA low while SCL is high. The block then owns the bus, `busy_o` rises and `done_o` pulses once SCL is low again.
- R2: Command code 2 (WRITE) sends `wr_data` MSB first while the block owns the bus, with `sda_oe_o`=1 meaning a 0 is driven. SDA changes only while SCL is low. A ninth bit is left released and read at its high-phase strobe: `acked_o` becomes 1 when SDA was low there and 0 when it was high.
- R3: START (code 1) issued while the block owns the bus first releases SDA during SCL low. It then pulls SDA low while SCL is high, and no STOP comes in between. `busy_o` stays 1 and ownership is kept.
- R4: Command code 3 (STOP) drives SDA low during SCL low and releases it at the next high-phase strobe. This gives an SDA rise while SCL is high. Ownership ends and `busy_o` drops.
- R5: A bit where the block releases SDA but SDA reads 0 at the high-phase strobe is a lost arbitration. `arb_lost_o` and `slave_rx_o` go to 1, and ownership, `run_o` and `sda_oe_o` go to 0. Two masters that send identical bits both keep going, with no loss.
- R6: Leaving the bus after a lost arbitration creates no STOP, so `busy_o` stays 1 until some master sends a STOP.
- R7: `arb_lost_o` holds until a one-cycle pulse on `clr_al`. While it is 1, every command is ignored, even on a free bus.
- R8: A START command from a block that does not own the bus is ignored while `busy_o` is 1.
- R9: `busy_o` rises after any START seen on the bus and falls after any STOP, whichever master sent them. A STOP also clears `slave_rx_o`.
- R10: WRITE and STOP commands are ignored while the block does not own the bus. No clock is requested and SDA is not driven.
- R11: After reset `busy_o`, `owner_o`, `arb_lost_o`, `slave_rx_o`, `run_o` and `sda_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe |
| wr_cmd | input | 2 | Command code: 0 none, 1 START, 2 WRITE, 3 STOP |
| wr_data | input | DATA_W | Byte to send with WRITE |
| clr_al | input | 1 | Clears the arbitration-lost flag |
| ph_low_i | input | 1 | Strobe at the middle of an SCL low phase |
| ph_hmid_i | input | 1 | Strobe at the middle of an SCL high phase |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| run_o | output | 1 | Request to the clock block to keep SCL running |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Bus held by some master |
| owner_o | output | 1 | This block holds the bus |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| slave_rx_o | output | 1 | Fallen back to slave receive after a loss |
| acked_o | output | 1 | Last ninth bit read low |
| done_o | output | 1 | One-cycle pulse when a command finishes |

## Verification
Bytes go out with no other master present, once acknowledged and once not. This separates the acknowledge read-back from the data path. A second master then sends the same byte as this block, and later a byte that is lower in the first bit where the two differ. Together these show that only a true 1-versus-0 conflict counts as a loss, and that the bus then carries the winner's byte with no STOP. Extra STARTs from the other master, and commands given while the flag is set or while the block does not own the bus, show that the busy, ownership and sticky-flag gates each refuse commands on their own.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_START = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_XFER_L,
        S_XFER_H,
        S_HOLD,
        S_PARK,
        S_STOP
    } eng_state_e;

    typedef struct packed {
        logic busy;
        logic scl_prev;
        logic sda_prev;
    } watch_t;

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy,
    output logic start_det,
    output logic stop_det
);
    watch_t w_d, w_q;

    always_comb begin
        w_d          = w_q;
        start_det    = scl_s && w_q.scl_prev && w_q.sda_prev && !sda_s;
        stop_det     = scl_s && w_q.scl_prev && !w_q.sda_prev && sda_s;
        w_d.scl_prev = scl_s;
        w_d.sda_prev = sda_s;
        if (start_det)     w_d.busy = 1'b1;
        else if (stop_det) w_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.busy     <= 1'b0;
            w_q.scl_prev <= 1'b1;
            w_q.sda_prev <= 1'b1;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy = w_q.busy;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy) else $error("busy not set after START"); // R9
    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy) else $error("busy not cleared after STOP"); // R9
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_al,
    input  logic              ph_low,
    input  logic              ph_hmid,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              busy,
    input  logic              stop_det,
    output logic              run_o,
    output logic              sda_oe_o,
    output logic              owner_o,
    output logic              al_o,
    output logic              slave_o,
    output logic              acked_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(DATA_W);

    typedef struct packed {
        eng_state_e        state;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  bidx;
        logic              sda_oe;
        logic              run;
        logic              owner;
        logic              al;
        logic              slave;
        logic              acked;
        logic              done;
    } eng_t;

    eng_t       r_d, r_q;
    cmd_e       cmd;
    logic       accept;
    logic       lose;
    eng_state_e st_q;

    assign st_q = r_q.state;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        lose     = 1'b0;
        cmd      = cmd_e'(wr_cmd);
        accept   = wr_en && !r_q.al;

        if (clr_al)   r_d.al    = 1'b0;
        if (stop_det) r_d.slave = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (accept && cmd == CMD_START && !busy) begin
                    r_d.state  = S_START;
                    r_d.sda_oe = 1'b0;
                    r_d.run    = 1'b1;
                end
            end
            S_PARK: begin
                if (accept) begin
                    case (cmd)
                        CMD_START: begin
                            r_d.state  = S_START;
                            r_d.sda_oe = 1'b0;
                            r_d.run    = 1'b1;
                        end
                        CMD_WRITE: begin
                            r_d.state  = S_XFER_H;
                            r_d.shreg  = wr_data;
                            r_d.bidx   = '0;
                            r_d.sda_oe = !wr_data[DATA_W-1];
                            r_d.run    = 1'b1;
                        end
                        CMD_STOP: begin
                            r_d.state  = S_STOP;
                            r_d.sda_oe = 1'b1;
                            r_d.run    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_START: begin
                if (ph_hmid) begin
                    if (sda_s) begin
                        r_d.sda_oe = 1'b1;
                        r_d.owner  = 1'b1;
                        r_d.state  = S_HOLD;
                    end else begin
                        lose = 1'b1;
                    end
                end
            end
            S_XFER_L: begin
                if (ph_low) begin
                    if (r_q.bidx == ACK_IDX) r_d.sda_oe = 1'b0;
                    else                     r_d.sda_oe = !r_q.shreg[DATA_W-1];
                    r_d.state = S_XFER_H;
                end
            end
            S_XFER_H: begin
                if (ph_hmid) begin
                    if (r_q.bidx == ACK_IDX) begin
                        r_d.acked = !sda_s;
                        r_d.state = S_HOLD;
                    end else if (!r_q.sda_oe && !sda_s) begin
                        lose = 1'b1;
                    end else begin
                        r_d.shreg = {r_q.shreg[DATA_W-2:0], 1'b0};
                        r_d.bidx  = r_q.bidx + 1'b1;
                        r_d.state = S_XFER_L;
                    end
                end
            end
            S_HOLD: begin
                if (ph_low) begin
                    r_d.run   = 1'b0;
                    r_d.state = S_PARK;
                    r_d.done  = 1'b1;
                end
            end
            S_STOP: begin
                if (ph_hmid) begin
                    r_d.sda_oe = 1'b0;
                    r_d.run    = 1'b0;
                    r_d.owner  = 1'b0;
                    r_d.state  = S_IDLE;
                    r_d.done   = 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase

        if (lose) begin
            r_d.sda_oe = 1'b0;
            r_d.run    = 1'b0;
            r_d.owner  = 1'b0;
            r_d.al     = 1'b1;
            r_d.slave  = 1'b1;
            r_d.state  = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, shreg: '0, bidx: '0, sda_oe: 1'b0,
                     run: 1'b0, owner: 1'b0, al: 1'b0, slave: 1'b0,
                     acked: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o    = r_q.run;
    assign sda_oe_o = r_q.sda_oe;
    assign owner_o  = r_q.owner;
    assign al_o     = r_q.al;
    assign slave_o  = r_q.slave;
    assign acked_o  = r_q.acked;
    assign done_o   = r_q.done;

    AST_SDA_MOVES_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && (r_q.sda_oe != $past(r_q.sda_oe)))
            |-> ($past(st_q) == S_START || $past(st_q) == S_STOP))
        else $error("SDA moved during SCL high outside START/STOP"); // R2
    AST_LOSS_LETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.slave |-> (!r_q.sda_oe && !r_q.owner))
        else $error("bus still driven in slave mode"); // R5
    AST_AL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.al) && !$past(clr_al)) |-> r_q.al)
        else $error("arbitration flag dropped without clear"); // R7
    AST_AL_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.al && wr_en && st_q == S_IDLE) |=> (st_q == S_IDLE))
        else $error("command taken while arbitration flag set"); // R7
    AST_NON_OWNER_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && wr_en && (wr_cmd == CMD_WRITE || wr_cmd == CMD_STOP))
            |=> (st_q == S_IDLE && !r_q.run))
        else $error("write or stop taken without ownership"); // R10
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_al,
    input  logic              ph_low_i,
    input  logic              ph_hmid_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              run_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              owner_o,
    output logic              arb_lost_o,
    output logic              slave_rx_o,
    output logic              acked_o,
    output logic              done_o
);
    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       busy, start_det, stop_det;

    i2c_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .busy      (busy),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_engine #(.DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .clr_al   (clr_al),
        .ph_low   (ph_low_i),
        .ph_hmid  (ph_hmid_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .busy     (busy),
        .stop_det (stop_det),
        .run_o    (run_o),
        .sda_oe_o (sda_oe_o),
        .owner_o  (owner_o),
        .al_o     (arb_lost_o),
        .slave_o  (slave_rx_o),
        .acked_o  (acked_o),
        .done_o   (done_o)
    );

    assign busy_o = busy;
endmodule

// File: tb/i2c_arb_master_tb_top.sv
module i2c_arb_master_tb_top;
    localparam int HALF     = 8;
    localparam int EV_START = 1000;
    localparam int EV_STOP  = 1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       wr_en = 1'b0;
    logic [1:0] wr_cmd = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       clr_al = 1'b0;
    logic       ph_low = 1'b0, ph_hmid = 1'b0, scl_m = 1'b1;
    int         cnt = 0;
    logic       agent_oe = 1'b0, oth_run = 1'b0;
    logic       sda_bus;
    logic       run_o, sda_oe, busy_o, owner_o, al_o, slave_o, acked_o, done_o;

    assign sda_bus = ~(sda_oe | agent_oe);

    i2c_arb_master dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .clr_al(clr_al), .ph_low_i(ph_low), .ph_hmid_i(ph_hmid), .scl_i(scl_m),
        .sda_i(sda_bus), .run_o(run_o), .sda_oe_o(sda_oe), .busy_o(busy_o),
        .owner_o(owner_o), .arb_lost_o(al_o), .slave_rx_o(slave_o),
        .acked_o(acked_o), .done_o(done_o)
    );

    // clock-synchronisation model: runs while any master requests clock
    always @(posedge clk) begin
        ph_low  <= 1'b0;
        ph_hmid <= 1'b0;
        if (!rst_n) begin
            scl_m <= 1'b1;
            cnt   <= 0;
        end else if (run_o || oth_run) begin
            if (cnt == HALF - 1) begin cnt <= 0; scl_m <= ~scl_m; end
            else cnt <= cnt + 1;
            if (cnt == HALF/2 - 1) begin
                if (scl_m) ph_hmid <= 1'b1;
                else       ph_low  <= 1'b1;
            end
        end else if (scl_m) begin
            cnt <= 0;
        end
    end

    int compared = 0, mismatched = 0;
    int exp_q[$];

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void ev_cmp(input int got);
        int e;
        compared++;
        if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL R2 bus event: actual %0d expected none", got);
        end else begin
            e = exp_q.pop_front();
            if (e != got) begin
                mismatched++;
                $display("FAIL R2 bus event: actual %0d expected %0d", got, e);
            end
        end
    endfunction

    // monitor: decodes START, STOP and bytes from the bus lines
    logic       pscl = 1'b1, psda = 1'b1;
    int         nb = 0;
    logic [7:0] sh = 8'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_m && pscl && psda && !sda_bus) begin
                ev_cmp(EV_START);
                nb = 0;
            end else if (scl_m && pscl && !psda && sda_bus) begin
                ev_cmp(EV_STOP);
            end else if (scl_m && !pscl) begin
                if (nb < 8) begin
                    sh = {sh[6:0], sda_bus};
                    nb++;
                    if (nb == 8) ev_cmp(int'(sh));
                end else begin
                    nb = 0;
                end
            end
            pscl = scl_m;
            psda = sda_bus;
        end
    end

    task automatic issue(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_start;
        exp_q.push_back(EV_START);
        issue(2'd1, 8'd0);
        @(posedge done_o);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_stop;
        exp_q.push_back(EV_STOP);
        issue(2'd3, 8'd0);
        @(posedge done_o);
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] d, input logic ack, input logic oth,
                        input logic [7:0] od, input logic [7:0] expb, input logic keep);
        exp_q.push_back(int'(expb));
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = 2'd2; wr_data = d;
        if (oth) begin oth_run = 1'b1; agent_oe = ~od[7]; end
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 6; k >= 0; k--) begin
            @(posedge ph_low); @(negedge clk);
            agent_oe = oth ? ~od[k] : 1'b0;
        end
        @(posedge ph_low); @(negedge clk);
        agent_oe = ack;
        @(posedge ph_low); @(negedge clk);
        agent_oe = 1'b0;
        if (!keep) oth_run = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic oth_start;
        exp_q.push_back(EV_START);
        @(negedge clk);
        agent_oe = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic oth_stop;
        exp_q.push_back(EV_STOP);
        oth_run = 1'b1;
        @(posedge ph_low); @(negedge clk);
        agent_oe = 1'b1;
        @(posedge ph_hmid); @(negedge clk);
        agent_oe = 1'b0;
        oth_run = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run;
        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R2 bus events missing: actual 0 expected %0d", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy_o, 0);
        chk("R11 owner", owner_o, 0);
        chk("R11 arb_lost", al_o, 0);
        chk("R11 slave_rx", slave_o, 0);
        chk("R11 run", run_o, 0);
        chk("R11 sda_oe", sda_oe, 0);

        // R10 write and stop without ownership
        issue(2'd2, 8'h5A);
        repeat (30) @(negedge clk);
        chk("R10 write ignored run", run_o, 0);
        chk("R10 write ignored sda", sda_oe, 0);
        issue(2'd3, 8'h00);
        repeat (30) @(negedge clk);
        chk("R10 stop ignored owner", owner_o, 0);
        chk("R10 stop ignored run", run_o, 0);

        // R1 fresh START
        do_start();
        chk("R1 owner", owner_o, 1);
        chk("R1 busy", busy_o, 1);

        // R2 bytes, acked and not acked
        xfer(8'hA6, 1'b1, 1'b0, 8'h00, 8'hA6, 1'b0);
        chk("R2 acked", acked_o, 1);
        xfer(8'h3C, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0);
        chk("R2 not acked", acked_o, 0);

        // R3 repeated START while owner
        do_start();
        chk("R3 owner kept", owner_o, 1);
        chk("R3 busy kept", busy_o, 1);

        // R5 identical bytes from two masters: no loss
        xfer(8'h55, 1'b1, 1'b1, 8'h55, 8'h55, 1'b0);
        chk("R5 equal bytes no loss", al_o, 0);
        chk("R5 equal bytes owner", owner_o, 1);
        chk("R2 acked after shared byte", acked_o, 1);

        // R4 STOP
        do_stop();
        chk("R4 owner released", owner_o, 0);
        chk("R4 busy cleared", busy_o, 0);

        // R5 loss at bit 5: 0xB0 vs 0x90, bus carries 0x90
        do_start();
        xfer(8'hB0, 1'b0, 1'b1, 8'h90, 8'h90, 1'b1);
        chk("R5 arb_lost", al_o, 1);
        chk("R5 slave_rx", slave_o, 1);
        chk("R5 owner dropped", owner_o, 0);
        chk("R5 sda released", sda_oe, 0);
        chk("R5 run dropped", run_o, 0);
        chk("R6 no stop, busy held", busy_o, 1);

        oth_stop();
        chk("R9 busy cleared by other STOP", busy_o, 0);
        chk("R9 slave_rx cleared by STOP", slave_o, 0);
        chk("R7 flag still set", al_o, 1);

        // R7 START on free bus ignored while flag set
        issue(2'd1, 8'd0);
        repeat (40) @(negedge clk);
        chk("R7 start ignored owner", owner_o, 0);
        chk("R7 start ignored run", run_o, 0);
        @(negedge clk); clr_al = 1'b1;
        @(negedge clk); clr_al = 1'b0;
        @(negedge clk);
        chk("R7 flag cleared", al_o, 0);

        // R8 START refused while another master holds the bus
        oth_start();
        chk("R9 busy from other START", busy_o, 1);
        issue(2'd1, 8'd0);
        repeat (40) @(negedge clk);
        chk("R8 start refused owner", owner_o, 0);
        chk("R8 start refused sda", sda_oe, 0);
        oth_stop();
        chk("R9 busy cleared again", busy_o, 0);

        // full transaction after recovery
        do_start();
        chk("R1 owner after recovery", owner_o, 1);
        xfer(8'hFF, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0);
        chk("R2 acked 0xFF", acked_o, 1);
        do_stop();
        chk("R4 final busy", busy_o, 0);

        finish_run();
    end
endmodule